// File: doc/BRIEF.md
# SPI Serial Memory Command Controller

This block is the device side of a serial nonvolatile memory reached over SPI. It decodes one 8-bit command at the start of every frame (chip select low) and carries it out. The commands are: set or clear the write enable latch, read or write the status register, read or write a small register-built byte array, and read a fixed identification word.

The SPI pins are asynchronous to the block's system clock. They pass through a synchronizer and are handled on detected SCK edges, so the system clock must run at least about eight times faster than SCK. The bus runs in mode 0 with MSB first. MOSI is taken at each SCK rising edge, and MISO moves on each SCK falling edge. Because the SPI side has no stall mechanism, there is no valid/ready handshake. The master sets the pace, and the block always keeps up within one SCK half period.

The write-protect bit and the two block-protect bits are stored and read back. They have no effect on writes. The array size is a power of two, and the array is cleared by reset.

Top module: `spi_cmd_mem`

## Requirements
- R1: The command byte is received MSB first on SCK rising edges and decoded as follows: 0x06 sets the write enable latch, 0x04 clears it, 0x05 reads the status, 0x01 writes the status, 0x03 reads the array, 0x02 writes the array, and 0x9F reads the ID. Each response bit appears on MISO after an SCK falling edge, starting with the falling edge that follows the 8th command bit.
- R2: If chip select rises before the 8th command bit, nothing is executed and no stored state changes.
- R3: The status byte reads as {bit7 write-protect flag, bits 6:4 spare, bits 3:2 block-protect, bit1 write enable latch, bit0 = 0}. A status write loads bits 7:2 from the first data byte. A status read repeats the status byte for as long as SCK runs.
- R4: 0x06 sets the write enable latch as soon as the command byte completes, and 0x04 clears it. A status write never changes the latch through its data byte.
- R5: The latch is cleared by reset, and on the chip select rising edge that ends a frame whose command was 0x01 or 0x02, whether or not that command wrote anything.
- R6: A status write or array write changes stored contents only if the latch was 1 when its command byte completed. Otherwise its data bytes are ignored.
- R7: An array read or write takes a 16-bit address MSB first, then data bytes. The address advances by one per data byte and wraps modulo DEPTH. Only its low log2(DEPTH) bits are used.
- R8: An array byte is stored only after all 8 of its bits have arrived. A partial byte at chip select rise is dropped.
- R9: 0x9F returns the four bytes of ID_WORD, most significant byte first, and repeats them cyclically.
- R10: After any other command byte, the rest of the frame is ignored, MISO stays 0, and no state changes.
- R11: While chip select is high, MISO is 0 and miso_oe is 0. Inside a frame, miso_oe is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock (mode 0) |
| mosi | input | 1 | Serial data from master |
| cs_n | input | 1 | Active-low chip select |
| miso | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output enable for MISO, high inside a frame |

## Verification
The assertions check on every cycle that the latch rises only on a received SCK edge. They also check that the latch is clear after a frame that must clear it ends, that the stored status bits move only at a completed status-write byte, that the bit counter moves only on SCK edges, that array writes occur only inside a frame, and that MISO is quiet outside frames. Only the bench scenarios can show the byte-level behaviour. That includes the write gating by the latch, address wrap, partial-byte and partial-command discard, ID repetition and the ignored unknown commands, which the bench checks against its own memory and status model.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam logic [7:0] CMD_LATCH_ON  = 8'h06;
  localparam logic [7:0] CMD_LATCH_OFF = 8'h04;
  localparam logic [7:0] CMD_STAT_RD   = 8'h05;
  localparam logic [7:0] CMD_STAT_WR   = 8'h01;
  localparam logic [7:0] CMD_MEM_RD    = 8'h03;
  localparam logic [7:0] CMD_MEM_WR    = 8'h02;
  localparam logic [7:0] CMD_IDENT     = 8'h9F;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_STAT_RD,
    PH_STAT_WR,
    PH_MEM_RD,
    PH_MEM_WR,
    PH_IDENT,
    PH_SKIP
  } phase_t;

  typedef struct packed {
    logic       prot_lock;
    logic [2:0] spare;
    logic [1:0] region;
  } stat_keep_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic mosi,
  input  logic cs_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s,
  output logic cs_hi,
  output logic cs_rise
);
  localparam logic [2:0] IDLE_V = 3'b100;

  logic [2:0] pin_v;
  logic [2:0] chain [STAGES];
  logic [1:0] prev;
  logic [2:0] last;

  assign pin_v = {cs_n, mosi, sck};

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[k] <= IDLE_V;
          else        chain[k] <= pin_v;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[k] <= IDLE_V;
          else        chain[k] <= chain[k-1];
        end
      end
    end
  endgenerate

  assign last = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 2'b10;
    else        prev <= {last[2], last[0]};
  end

  assign sck_rise = last[0] & ~prev[0];
  assign sck_fall = ~last[0] & prev[0];
  assign mosi_s   = last[1];
  assign cs_hi    = last[2];
  assign cs_rise  = last[2] & ~prev[1];
endmodule

// File: rtl/spi_reg_array.sv
module spi_reg_array #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] cells [DEPTH];

  genvar w;
  generate
    for (w = 0; w < DEPTH; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        cells[w] <= '0;
        else if (we && (waddr == AW'(w)))  cells[w] <= wdata;
      end
    end
  endgenerate

  assign rdata = cells[raddr];
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int          DEPTH   = 64,
  parameter logic [31:0] ID_WORD = 32'h3C_A5_01_64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi_s,
  input  logic          cs_hi,
  input  logic          cs_rise,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic [AW-1:0] mem_raddr,
  input  logic [7:0]    mem_rdata,
  output logic          miso_q,
  output logic          miso_oe
);
  phase_t     phase;
  logic [2:0] bitc;
  logic [6:0] sh;
  logic [7:0] addr_hi;
  logic       addr_second;
  logic       addr_is_wr;
  logic [AW-1:0] ptr;
  logic [1:0] idx;
  logic       wr_ok;
  logic       clr_pend;
  logic       wel;
  stat_keep_t keep;
  logic [7:0] tx_sh;
  logic [7:0] byte_in;
  logic       byte_done;
  logic [7:0] stat_now;
  logic [7:0] id_sel;

  assign byte_in   = {sh, mosi_s};
  assign byte_done = sck_rise && !cs_hi && (bitc == 3'd7);
  assign stat_now  = {keep, wel, 1'b0};

  always_comb begin
    case (idx)
      2'd0:    id_sel = ID_WORD[31:24];
      2'd1:    id_sel = ID_WORD[23:16];
      2'd2:    id_sel = ID_WORD[15:8];
      default: id_sel = ID_WORD[7:0];
    endcase
  end

  assign mem_we    = byte_done && (phase == PH_MEM_WR) && wr_ok;
  assign mem_waddr = ptr;
  assign mem_wdata = byte_in;
  assign mem_raddr = (phase == PH_ADDR) ? AW'({addr_hi, byte_in}) : ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_CMD;
      bitc        <= '0;
      sh          <= '0;
      addr_hi     <= '0;
      addr_second <= 1'b0;
      addr_is_wr  <= 1'b0;
      ptr         <= '0;
      idx         <= '0;
      wr_ok       <= 1'b0;
      clr_pend    <= 1'b0;
      wel         <= 1'b0;
      keep        <= '0;
      tx_sh       <= '0;
      miso_q      <= 1'b0;
      miso_oe     <= 1'b0;
    end else begin
      miso_oe <= ~cs_hi;
      if (cs_hi) begin
        phase       <= PH_CMD;
        bitc        <= '0;
        addr_second <= 1'b0;
        idx         <= '0;
        tx_sh       <= '0;
        miso_q      <= 1'b0;
        if (cs_rise) begin
          if (clr_pend) wel <= 1'b0;
          clr_pend <= 1'b0;
          wr_ok    <= 1'b0;
        end
      end else begin
        if (sck_fall) begin
          miso_q <= tx_sh[7];
          tx_sh  <= {tx_sh[6:0], 1'b0};
        end
        if (sck_rise) begin
          bitc <= bitc + 3'd1;
          sh   <= byte_in[6:0];
          if (bitc == 3'd7) begin
            tx_sh <= '0;
            case (phase)
              PH_CMD: begin
                case (byte_in)
                  CMD_LATCH_ON: begin
                    wel   <= 1'b1;
                    phase <= PH_SKIP;
                  end
                  CMD_LATCH_OFF: begin
                    wel   <= 1'b0;
                    phase <= PH_SKIP;
                  end
                  CMD_STAT_RD: begin
                    tx_sh <= stat_now;
                    phase <= PH_STAT_RD;
                  end
                  CMD_STAT_WR: begin
                    wr_ok    <= wel;
                    clr_pend <= 1'b1;
                    phase    <= PH_STAT_WR;
                  end
                  CMD_MEM_RD: begin
                    addr_is_wr <= 1'b0;
                    phase      <= PH_ADDR;
                  end
                  CMD_MEM_WR: begin
                    addr_is_wr <= 1'b1;
                    wr_ok      <= wel;
                    clr_pend   <= 1'b1;
                    phase      <= PH_ADDR;
                  end
                  CMD_IDENT: begin
                    tx_sh <= ID_WORD[31:24];
                    idx   <= 2'd1;
                    phase <= PH_IDENT;
                  end
                  default: phase <= PH_SKIP;
                endcase
              end
              PH_ADDR: begin
                addr_second <= ~addr_second;
                if (!addr_second) begin
                  addr_hi <= byte_in;
                end else if (addr_is_wr) begin
                  ptr   <= AW'({addr_hi, byte_in});
                  phase <= PH_MEM_WR;
                end else begin
                  ptr   <= AW'({addr_hi, byte_in}) + AW'(1);
                  tx_sh <= mem_rdata;
                  phase <= PH_MEM_RD;
                end
              end
              PH_STAT_RD: tx_sh <= stat_now;
              PH_STAT_WR: begin
                if (wr_ok) keep <= byte_in[7:2];
                phase <= PH_SKIP;
              end
              PH_MEM_RD: begin
                tx_sh <= mem_rdata;
                ptr   <= ptr + AW'(1);
              end
              PH_MEM_WR: ptr <= ptr + AW'(1);
              PH_IDENT: begin
                tx_sh <= id_sel;
                idx   <= idx + 2'd1;
              end
              default: tx_sh <= '0;
            endcase
          end
        end
      end
    end
  end

  // R5
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && clr_pend) |=> !wel);

  // R4
  wel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_rise |=> !$rose(wel));

  // R3
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_done && phase == PH_STAT_WR) |=> $stable(keep));

  // R1
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_rise && !cs_hi) |=> $stable(bitc));

  // R6
  write_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (!cs_hi && clr_pend));

  // R11
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_hi) |-> (!miso_q && !miso_oe));
endmodule

// File: rtl/spi_cmd_mem.sv
module spi_cmd_mem #(
  parameter int          DEPTH       = 64,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] ID_WORD     = 32'h3C_A5_01_64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic mosi,
  input  logic cs_n,
  output logic miso,
  output logic miso_oe
);
  localparam int AW = $clog2(DEPTH);

  logic          sck_rise, sck_fall, mosi_s, cs_hi, cs_rise;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [7:0]    mem_wdata, mem_rdata;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .mosi     (mosi),
    .cs_n     (cs_n),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_s   (mosi_s),
    .cs_hi    (cs_hi),
    .cs_rise  (cs_rise)
  );

  spi_cmd_engine #(.DEPTH(DEPTH), .ID_WORD(ID_WORD)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .mosi_s    (mosi_s),
    .cs_hi     (cs_hi),
    .cs_rise   (cs_rise),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .mem_raddr (mem_raddr),
    .mem_rdata (mem_rdata),
    .miso_q    (miso),
    .miso_oe   (miso_oe)
  );

  spi_reg_array #(.DEPTH(DEPTH), .WIDTH(8)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );
endmodule

// File: tb/spi_cmd_mem_bench.sv
`timescale 1ns/1ps
module spi_cmd_mem_bench;
  localparam int          DEPTH = 64;
  localparam logic [31:0] IDW   = 32'h3C_A5_01_64;
  localparam int          H     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic cs_n = 1'b1;
  logic miso, miso_oe;

  int tests = 0;
  int fails = 0;

  logic [7:0] mem_m [DEPTH];
  logic [5:0] keep_m = '0;
  logic       wel_m = 1'b0;

  always #2.5 clk = ~clk;

  spi_cmd_mem #(.DEPTH(DEPTH), .ID_WORD(IDW)) u_spi_cmd_mem (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n),
    .miso(miso), .miso_oe(miso_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic xbit(input logic b, output logic r);
    @(negedge clk) mosi = b;
    repeat (H) @(negedge clk);
    r = miso;
    sck = 1'b1;
    repeat (H) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      xbit(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic fbegin;
    @(negedge clk) cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic fend;
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * H) @(negedge clk);
  endtask

  task automatic do_simple(input logic [7:0] op);
    logic [7:0] rx;
    fbegin; xbyte(op, rx); fend;
    if (op == 8'h06) wel_m = 1'b1;
    if (op == 8'h04) wel_m = 1'b0;
  endtask

  task automatic do_rdsr(input int n, input string tag);
    logic [7:0] rx;
    fbegin; xbyte(8'h05, rx);
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00, rx);
      chk(tag, rx, {keep_m, wel_m, 1'b0});
    end
    fend;
  endtask

  task automatic do_wrsr(input logic [7:0] v);
    logic [7:0] rx;
    fbegin; xbyte(8'h01, rx); xbyte(v, rx); fend;
    if (wel_m) keep_m = v[7:2];
    wel_m = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d[$], input int tail);
    logic [7:0] rx;
    logic r;
    fbegin; xbyte(8'h02, rx); xbyte(a[15:8], rx); xbyte(a[7:0], rx);
    foreach (d[i]) xbyte(d[i], rx);
    for (int i = 0; i < tail; i++) xbit(1'b1, r);
    fend;
    if (wel_m) foreach (d[i]) mem_m[(int'(a) + i) % DEPTH] = d[i];
    wel_m = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, input int n, input string tag);
    logic [7:0] rx;
    fbegin; xbyte(8'h03, rx); xbyte(a[15:8], rx); xbyte(a[7:0], rx);
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00, rx);
      chk(tag, rx, mem_m[(int'(a) + i) % DEPTH]);
    end
    fend;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    logic r;
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 reset state, bus idle
    chk("R11 miso idle", miso, 0);
    chk("R11 oe idle", miso_oe, 0);
    // R5 status after reset, repeated (R3)
    do_rdsr(2, "R5 R3 reset status");

    // R6 write without latch ignored
    do_write(16'h0005, '{8'h5A}, 0);
    do_read(16'h0005, 1, "R6 gated write");

    // R4 latch set (R1 command 0x06)
    do_simple(8'h06);
    do_rdsr(1, "R4 R1 latch set");

    // R2 partial command keeps latch
    fbegin;
    for (int i = 0; i < 4; i++) xbit(1'b0, r);
    fend;
    do_rdsr(1, "R2 partial command");

    // R7 wrap write, R8 partial tail byte, R11 oe in frame
    fbegin; xbyte(8'h00, rx); chk("R11 oe in frame", miso_oe, 1); fend;
    do_write(16'h003E, '{8'hA1, 8'hB2, 8'hC3}, 4);
    do_rdsr(1, "R5 latch cleared by write");
    do_read(16'h003E, 4, "R7 R8 wrap read");
    do_read(16'hFF40, 2, "R7 high address bits");

    // R3 status write with latch, R5 clear after
    do_simple(8'h06);
    do_wrsr(8'hFF);
    do_rdsr(2, "R3 R5 status write");
    do_wrsr(8'h00);
    do_rdsr(1, "R6 gated status write");
    do_simple(8'h06);
    do_wrsr(8'h72);
    do_rdsr(1, "R4 status write keeps latch rule");

    // R4 latch clear command
    do_simple(8'h06);
    do_simple(8'h04);
    do_rdsr(1, "R4 latch clear");

    // R9 identification repeats
    fbegin; xbyte(8'h9F, rx);
    for (int i = 0; i < 6; i++) begin
      xbyte(8'h00, rx);
      chk("R9 ident byte", rx, IDW[8*(3 - (i % 4)) +: 8]);
    end
    fend;

    // R10 unknown command ignored
    do_simple(8'h06);
    fbegin; xbyte(8'hAA, rx);
    xbyte(8'h04, rx); chk("R10 miso quiet", rx, 0);
    xbyte(8'h02, rx); chk("R10 miso quiet", rx, 0);
    xbyte(8'h00, rx); xbyte(8'h07, rx); xbyte(8'h99, rx);
    chk("R10 miso quiet", rx, 0);
    fend;
    do_rdsr(1, "R10 latch untouched");
    do_read(16'h0007, 1, "R10 array untouched");
    chk("R11 miso after frame", miso, 0);

    // R7 write with latch then read back at another wrap point
    do_write(16'h1234, '{8'h11, 8'h22}, 0);
    do_read(16'h0034, 2, "R7 address low bits");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule